// File: doc/BRIEF.md
# PLL Configuration and Startup Sequencer

This block takes a clock-multiplier PLL from whatever state it is in and brings it to a new configuration. It holds a small register bank that controls the PLL: a connect bit, an enable bit, a multiplier/pre-divider configuration word, a CPU clock divider and a clock source select. The connect and enable bits and the configuration word each have a shadow copy. They reach the active controls only through a two-write unlock handshake on a feed address. The divider and the source select take effect as soon as they are written.

A start pulse launches a fixed sequence of internal bus writes. If the PLL is connected, the sequencer first drops the connect bit and commits it. It then drops the enable bit and commits it. If a flag asks for it, it writes the CPU divider. It then writes the clock source. Last, it writes the new multiplier word and commits it. A host write port gives direct access to the same bank while the sequencer is idle. That port prepares the PLL state before a sequence, and through it the commit and write-protection rules can be observed on their own. Lock detection, reconnection after lock and the analog PLL are outside this block.

Top module: `pllseq_top`

## Requirements
- R1: While the synchronous active-high `rst` is high and after it falls, `pll_connect`, `pll_enable`, `pll_cfg`, `cpu_div`, `clk_src` (0 = internal oscillator), `busy`, `done` and `error` are all zero.
- R2: The configuration word holds M-1 in bits 14:0 and N-1 in bits 23:16, and all other bits are zero. M=8789 with N=2 gives 0x00012254. A host write of 0xFFFFFFFF to the config address (address 1), once committed, reads 0x00FF7FFF.
- R3: Count edges from the clock edge that samples `start`. For a connected PLL, `pll_connect` falls after edge 4 and `pll_enable` falls 3 edges later. The optional divider write takes 1 edge, then the source write takes 1 edge, then `pll_cfg` takes its new value 3 edges after the source write.
- R4: When `pll_connect` is low at start, the disconnect step is skipped and the whole sequence is 3 edges shorter.
- R5: `cpu_div` is written only when `div_req` is high. Otherwise it keeps its prior value and the sequence is 1 edge shorter.
- R6: The shadow control bits (address 0: bit 1 connect, bit 0 enable) and the shadow config word move to the active outputs only when a write of 0xAA to the feed address (address 2) is followed by a write of 0x55 to it as the next write. Any other write in between aborts the commit. The shadow values are kept for a later handshake.
- R7: A write to the config address while `pll_enable` is high is ignored.
- R8: `busy` is high from the edge after an accepted start until the sequence ends. A `start` while busy is ignored.
- R9: `done` is high for exactly one cycle, in the same cycle that the new `pll_cfg` appears and `busy` falls.
- R10: A start with M=0, M>32768, N=0 or N>256 raises `error` for one cycle, leaves `busy` low and changes no output register.
- R11: Host writes (address 3 divider, address 4 source) are dropped while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts the sequence |
| req_m | input | 16 | Requested multiplier M |
| req_n | input | 9 | Requested pre-divider N |
| req_div | input | 8 | Requested CPU clock divider |
| div_req | input | 1 | Apply req_div during the sequence |
| req_src | input | 2 | Requested clock source |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write address |
| host_wdata | input | 32 | Host write data |
| pll_connect | output | 1 | Active PLL connect control |
| pll_enable | output | 1 | Active PLL enable control |
| pll_cfg | output | 32 | Active multiplier/pre-divider word |
| cpu_div | output | 8 | Active CPU clock divider |
| clk_src | output | 2 | Active clock source select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle invalid-request pulse |

## Verification
The sequence is run from random M, N, divider and source values, with the PLL starting either connected or not and with the divider flag set or clear. Before each run the prior values are set to differ from the requested ones, so the edge at which each output first reaches its new value shows both the step order and whether the disconnect or divider step was skipped. Directed cases use the field limits (M=1/N=1, M=32768/N=256, and one value just past each limit) to separate valid from refused requests. They also use an interrupted feed pair, which must not commit while a clean pair afterwards must, and a config write while enabled, which must not take. A second start and a host divider write issued mid-sequence must leave both the result and the timing unchanged.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    parameter int M_W    = 15;
    parameter int N_W    = 8;
    parameter int N_LSB  = 16;
    parameter int DIV_W  = 8;
    parameter int SRC_W  = 2;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 3;

    localparam logic [DATA_W-1:0] FEED_KEY1 = 32'h0000_00AA;
    localparam logic [DATA_W-1:0] FEED_KEY2 = 32'h0000_0055;
    localparam logic [DATA_W-1:0] CFG_MASK  =
        DATA_W'((1 << M_W) - 1) | (DATA_W'((1 << N_W) - 1) << N_LSB);

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_CFG  = 3'd1,
        A_FEED = 3'd2,
        A_DIV  = 3'd3,
        A_SRC  = 3'd4
    } addr_e;

    typedef struct packed {
        logic connect;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic              wr;
        addr_e             addr;
        logic [DATA_W-1:0] data;
    } bus_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DISC_W, S_DISC_A, S_DISC_B,
        S_DIS_W,  S_DIS_A,  S_DIS_B,
        S_DIV,    S_SRC,
        S_CFG_W,  S_CFG_A,  S_CFG_B
    } state_e;

    function automatic logic req_ok(input logic [M_W:0] m, input logic [N_W:0] n);
        return (m != '0) && (int'(m) <= (1 << M_W)) &&
               (n != '0) && (int'(n) <= (1 << N_W));
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input logic [M_W:0] m,
                                                  input logic [N_W:0] n);
        logic [DATA_W-1:0] w;
        logic [M_W:0]      mm;
        logic [N_W:0]      nn;
        mm = m - 1'b1;
        nn = n - 1'b1;
        w  = '0;
        w[M_W-1:0]        = mm[M_W-1:0];
        w[N_LSB +: N_W]   = nn[N_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/pllseq_feed.sv
module pllseq_feed
    import pllseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t bus,
    output logic commit
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (bus.wr) begin
            armed <= (bus.addr == A_FEED) && (bus.data == FEED_KEY1);
        end
    end

    assign commit = bus.wr && armed && (bus.addr == A_FEED) && (bus.data == FEED_KEY2);

endmodule

// File: rtl/pllseq_regs.sv
module pllseq_regs
    import pllseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_t              bus,
    input  logic              commit,
    output ctrl_t             act_ctrl,
    output logic [DATA_W-1:0] act_cfg,
    output logic [DIV_W-1:0]  act_div,
    output logic [SRC_W-1:0]  act_src
);
    ctrl_t             sh_ctrl;
    logic [DATA_W-1:0] sh_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_ctrl  <= '0;
            sh_cfg   <= '0;
            act_ctrl <= '0;
            act_cfg  <= '0;
            act_div  <= '0;
            act_src  <= '0;
        end else begin
            if (bus.wr) begin
                case (bus.addr)
                    A_CTRL: sh_ctrl <= ctrl_t'(bus.data[1:0]);
                    A_CFG:  if (!act_ctrl.enable) sh_cfg <= bus.data & CFG_MASK;
                    A_DIV:  act_div <= bus.data[DIV_W-1:0];
                    A_SRC:  act_src <= bus.data[SRC_W-1:0];
                    default: ;
                endcase
            end
            if (commit) begin
                act_ctrl <= sh_ctrl;
                act_cfg  <= sh_cfg;
            end
        end
    end

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [M_W:0]     req_m,
    input  logic [N_W:0]     req_n,
    input  logic [DIV_W-1:0] req_div,
    input  logic             div_req,
    input  logic [SRC_W-1:0] req_src,
    input  ctrl_t            act_ctrl,
    output bus_t             seq_bus,
    output logic             busy,
    output logic             done,
    output logic             error
);
    state_e           state;
    logic [M_W:0]     r_m;
    logic [N_W:0]     r_n;
    logic [DIV_W-1:0] r_div;
    logic             r_dreq;
    logic [SRC_W-1:0] r_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            done   <= 1'b0;
            error  <= 1'b0;
            r_m    <= '0;
            r_n    <= '0;
            r_div  <= '0;
            r_dreq <= 1'b0;
            r_src  <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (req_ok(req_m, req_n)) begin
                            r_m    <= req_m;
                            r_n    <= req_n;
                            r_div  <= req_div;
                            r_dreq <= div_req;
                            r_src  <= req_src;
                            state  <= act_ctrl.connect ? S_DISC_W : S_DIS_W;
                        end else begin
                            error <= 1'b1;
                        end
                    end
                end
                S_DIS_B: state <= r_dreq ? S_DIV : S_SRC;
                S_CFG_B: begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end
                default: state <= state_e'(state + 4'd1);
            endcase
        end
    end

    assign busy = (state != S_IDLE);

    always_comb begin
        seq_bus = '{wr: 1'b0, addr: A_CTRL, data: '0};
        case (state)
            S_DISC_W: seq_bus = '{wr: 1'b1, addr: A_CTRL,
                                  data: DATA_W'({1'b0, act_ctrl.enable})};
            S_DIS_W:  seq_bus = '{wr: 1'b1, addr: A_CTRL, data: '0};
            S_DISC_A, S_DIS_A, S_CFG_A:
                      seq_bus = '{wr: 1'b1, addr: A_FEED, data: FEED_KEY1};
            S_DISC_B, S_DIS_B, S_CFG_B:
                      seq_bus = '{wr: 1'b1, addr: A_FEED, data: FEED_KEY2};
            S_DIV:    seq_bus = '{wr: 1'b1, addr: A_DIV, data: DATA_W'(r_div)};
            S_SRC:    seq_bus = '{wr: 1'b1, addr: A_SRC, data: DATA_W'(r_src)};
            S_CFG_W:  seq_bus = '{wr: 1'b1, addr: A_CFG, data: cfg_word(r_m, r_n)};
            default: ;
        endcase
    end

endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
    import pllseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [M_W:0]      req_m,
    input  logic [N_W:0]      req_n,
    input  logic [DIV_W-1:0]  req_div,
    input  logic              div_req,
    input  logic [SRC_W-1:0]  req_src,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              pll_connect,
    output logic              pll_enable,
    output logic [DATA_W-1:0] pll_cfg,
    output logic [DIV_W-1:0]  cpu_div,
    output logic [SRC_W-1:0]  clk_src,
    output logic              busy,
    output logic              done,
    output logic              error
);
    bus_t  seq_bus;
    bus_t  host_bus;
    bus_t  bus;
    logic  commit;
    ctrl_t act_ctrl;

    assign host_bus = '{wr: host_wr, addr: addr_e'(host_addr), data: host_wdata};
    assign bus      = busy ? seq_bus : host_bus;

    pllseq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .req_m    (req_m),
        .req_n    (req_n),
        .req_div  (req_div),
        .div_req  (div_req),
        .req_src  (req_src),
        .act_ctrl (act_ctrl),
        .seq_bus  (seq_bus),
        .busy     (busy),
        .done     (done),
        .error    (error)
    );

    pllseq_feed u_feed (
        .clk    (clk),
        .rst    (rst),
        .bus    (bus),
        .commit (commit)
    );

    pllseq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .commit   (commit),
        .act_ctrl (act_ctrl),
        .act_cfg  (pll_cfg),
        .act_div  (cpu_div),
        .act_src  (clk_src)
    );

    assign pll_connect = act_ctrl.connect;
    assign pll_enable  = act_ctrl.enable;

endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk
    import pllseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              commit,
    input logic              pll_connect,
    input logic              pll_enable,
    input logic [DATA_W-1:0] pll_cfg
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_end_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_cfg) |-> !$past(pll_enable));

    p_cfg_fields_r2: assert property (@(posedge clk) disable iff (rst)
        (pll_cfg[DATA_W-1:N_LSB+N_W] == '0) && (pll_cfg[N_LSB-1:M_W] == '0));

    p_commit_only_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pll_cfg) || !$stable(pll_connect) || !$stable(pll_enable))
            |-> $past(commit));

    p_disc_first_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_enable) |-> !pll_connect);

    p_err_idle_r10: assert property (@(posedge clk) disable iff (rst)
        error |-> (!busy && !$past(busy)));

endmodule

bind pllseq_top pllseq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .commit      (commit),
    .pll_connect (pll_connect),
    .pll_enable  (pll_enable),
    .pll_cfg     (pll_cfg)
);

// File: tb/pllseq_top_test.sv
module pllseq_top_test;
    import pllseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [M_W:0]      req_m = '0;
    logic [N_W:0]      req_n = '0;
    logic [DIV_W-1:0]  req_div = '0;
    logic              div_req = 1'b0;
    logic [SRC_W-1:0]  req_src = '0;
    logic              host_wr = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              pll_connect, pll_enable, busy, done, error;
    logic [DATA_W-1:0] pll_cfg;
    logic [DIV_W-1:0]  cpu_div;
    logic [SRC_W-1:0]  clk_src;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10ns clk = ~clk;

    pllseq_top uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int m, input int n);
        return (32'(n - 1) & 32'hFF) << 16 | (32'(m - 1) & 32'h7FFF);
    endfunction

    function automatic int seq_len(input bit c, input bit d);
        return 1 + (c ? 3 : 0) + 3 + (d ? 1 : 0) + 1 + 3;
    endfunction

    task automatic hw(input int a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic feed();
        hw(2, 32'hAA);
        hw(2, 32'h55);
    endtask

    task automatic setup(input bit conn, input logic [31:0] cfg_pre,
                         input logic [7:0] div_pre, input logic [1:0] src_pre);
        hw(0, 32'h0); feed();
        hw(1, cfg_pre); feed();
        hw(0, {30'b0, conn, 1'b1}); feed();
        hw(3, 32'(div_pre));
        hw(4, 32'(src_pre));
    endtask

    task automatic run_seq(input int m, input int n, input logic [7:0] dv, input bit dr,
                           input logic [1:0] sr, input bit disturb);
        bit c;
        logic [7:0] pre_div;
        int i, tc, te, td, ts, tg, tdone;
        logic [31:0] exp_cfg;
        c = pll_connect;
        pre_div = cpu_div;
        exp_cfg = enc(m, n);
        tc = -1; te = -1; td = -1; ts = -1; tg = -1; tdone = -1;
        @(negedge clk);
        start = 1'b1; req_m = 16'(m); req_n = 9'(n); req_div = dv; div_req = dr; req_src = sr;
        @(negedge clk);
        start = 1'b0;
        i = 1;
        while (i < 40) begin
            if (!pll_connect && tc < 0) tc = i;
            if (!pll_enable && te < 0) te = i;
            if (cpu_div == dv && td < 0) td = i;
            if (clk_src == sr && ts < 0) ts = i;
            if (pll_cfg == exp_cfg && tg < 0) tg = i;
            if (done) begin
                tdone = i;
                chk(busy == 1'b0, "R9", "busy at done", busy, 0);
                break;
            end
            chk(busy == 1'b1, "R8", "busy during sequence", busy, 1);
            if (disturb && i == 5) begin
                start = 1'b1; req_m = 16'd7; req_n = 9'd3; req_div = 8'h5A; div_req = 1'b1;
                host_wr = 1'b1; host_addr = 3'd3; host_wdata = 32'h5A;
            end else begin
                start = 1'b0; host_wr = 1'b0;
            end
            @(negedge clk);
            i++;
        end
        start = 1'b0; host_wr = 1'b0;
        chk(tdone == seq_len(c, dr), c ? "R3" : "R4", "sequence length", tdone, seq_len(c, dr));
        chk(tc == (c ? 4 : 1), "R3", "disconnect edge", tc, c ? 4 : 1);
        chk(te == 1 + (c ? 3 : 0) + 3, "R3", "disable edge", te, 1 + (c ? 3 : 0) + 3);
        if (dr) chk(td == 1 + (c ? 3 : 0) + 4, "R5", "divider edge", td, 1 + (c ? 3 : 0) + 4);
        else    chk(cpu_div == pre_div, "R5", "divider kept", cpu_div, pre_div);
        chk(ts == 1 + (c ? 3 : 0) + 4 + (dr ? 1 : 0), "R3", "source edge", ts,
            1 + (c ? 3 : 0) + 4 + (dr ? 1 : 0));
        chk(tg == tdone, "R9", "config edge", tg, tdone);
        chk(pll_cfg == exp_cfg, "R2", "config word", pll_cfg, exp_cfg);
        if (disturb)
            chk(cpu_div == (dr ? dv : pre_div), "R11", "host write during busy", cpu_div,
                dr ? dv : pre_div);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
        chk(busy == 1'b0, "R8", "idle after done", busy, 0);
    endtask

    task automatic bad_start(input int m, input int n);
        logic [31:0] cfg0;
        logic [7:0]  div0;
        logic [1:0]  src0;
        cfg0 = pll_cfg; div0 = cpu_div; src0 = clk_src;
        @(negedge clk);
        start = 1'b1; req_m = 16'(m); req_n = 9'(n); req_div = ~div0; div_req = 1'b1;
        req_src = ~src0;
        @(negedge clk);
        start = 1'b0;
        chk(error == 1'b1, "R10", "error raised", error, 1);
        chk(busy == 1'b0, "R10", "busy stays low", busy, 0);
        repeat (12) @(negedge clk);
        chk(error == 1'b0, "R10", "error one cycle", error, 0);
        chk(pll_cfg == cfg0 && cpu_div == div0 && clk_src == src0, "R10", "no change",
            {pll_cfg, cpu_div, clk_src}, {cfg0, div0, src0});
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk({pll_connect, pll_enable, pll_cfg, cpu_div, clk_src, busy, done, error} == '0,
            "R1", "outputs in reset", pll_cfg, 0);
        rst = 1'b0;
        @(negedge clk);
        chk({pll_connect, pll_enable, pll_cfg, cpu_div, clk_src, busy, done, error} == '0,
            "R1", "outputs after reset", {pll_connect, pll_enable, pll_cfg}, 0);

        // R2 field mask through host path
        hw(1, 32'hFFFF_FFFF); feed();
        chk(pll_cfg == 32'h00FF_7FFF, "R2", "field mask", pll_cfg, 32'h00FF_7FFF);

        // R6 aborted feed, then clean feed transfers kept shadow
        hw(1, 32'h0001_0003);
        hw(2, 32'hAA); hw(3, 32'h7); hw(2, 32'h55);
        chk(pll_cfg == 32'h00FF_7FFF, "R6", "aborted commit", pll_cfg, 32'h00FF_7FFF);
        feed();
        chk(pll_cfg == 32'h0001_0003, "R6", "clean commit", pll_cfg, 32'h0001_0003);

        // R7 config write while enabled
        hw(0, 32'h1); feed();
        hw(1, 32'h0000_1234); feed();
        chk(pll_cfg == 32'h0001_0003, "R7", "write while enabled", pll_cfg, 32'h0001_0003);

        // directed: example encoding, connected, with divider, disturbed
        setup(1'b1, enc(8789, 2) ^ 32'h1, 8'h10, 2'd0);
        run_seq(8789, 2, 8'h11, 1'b1, 2'd1, 1'b1);
        chk(pll_cfg == 32'h0001_2254, "R2", "example word", pll_cfg, 32'h0001_2254);
        // limits
        setup(1'b0, 32'h1, 8'h3, 2'd3);
        run_seq(32768, 256, 8'h2, 1'b0, 2'd2, 1'b0);
        setup(1'b1, 32'h1, 8'h3, 2'd3);
        run_seq(1, 1, 8'h2, 1'b0, 2'd2, 1'b1);

        // R10 refused requests
        bad_start(0, 4);
        bad_start(32769, 4);
        bad_start(100, 0);
        bad_start(100, 257);

        // random runs
        for (int k = 0; k < 20; k++) begin
            int m, n;
            logic [7:0] dv;
            logic [1:0] sr;
            bit dr, c;
            m  = 1 + int'($urandom % 32768);
            n  = 1 + int'($urandom % 256);
            dv = 8'($urandom);
            sr = 2'($urandom);
            dr = 1'($urandom);
            c  = 1'($urandom);
            setup(c, enc(m, n) ^ 32'h1, dv ^ 8'h1, sr ^ 2'h1);
            run_seq(m, n, dv, dr, sr, 1'($urandom));
        end
        report();
    end

endmodule